// File: doc/BRIEF.md
# Burst Read Cache with Write-Through

This block sits between a requester and backing memory. Both sides use the same memory-mapped handshake: read and write strobes, a word address, write data, byte enables, a burst length and a wait signal, plus a data-valid strobe that returns read beats. The upstream (slave) port takes single writes and burst reads. The downstream (master) port issues one request at a time to memory.

Reads are served from a direct-mapped store. Each line holds one data word, a tag and a valid bit. The controller first scans every beat of a read burst against the store, one beat per cycle. If every beat hits, the words are returned from the store, one per cycle. If any beat misses, the whole burst goes to memory with the same start address and length. The returned words fill the store and are passed upstream in order as they arrive.

Writes are write-through. A write that hits merges its enabled bytes into the stored word. A write that misses leaves the store untouched. In both cases the write is forwarded to memory. The slave port holds wait high while a request is being handled, so only one transaction is in flight at any time.

Top module: `mm_cache`

## Requirements
- R1: After reset, every line is invalid, so the first read of any address misses. In the first cycle after reset is released, the master port issues neither read nor write. Slave read-data-valid stays low during reset.
- R2: The master port never raises read and write in the same cycle.
- R3: While a master request is raised and memory holds wait high, the master read, write, address, write data, byte enables and burst length all keep their values.
- R4: Every accepted master read carries a nonzero burst length. A slave read accepted with burst length 0 is handled as a one-beat read.
- R5: The slave wait output is high in every cycle with read beats outstanding. The only exception is the cycle that delivers the last outstanding beat. Wait is low again once the block is idle.
- R6: Slave read-data-valid never rises with no beats outstanding. An accepted read returns exactly its burst length in beats, in increasing address order: beat k carries the word at start address plus k.
- R7: When every beat of a read burst is present in the store, the burst is served without any master read.
- R8: When any beat of a read burst misses, exactly one master read burst is issued, with the same start address and length. Its beats fill the store and are forwarded upstream in order. No new master request is raised while beats from memory are still outstanding.
- R9: Each slave write produces exactly one master write with the same address, data and byte enables, and a burst length of 1 whatever slave burst length came with it. On a hit, only the enabled bytes of the stored word change. A miss does not allocate a line.
- R10: A read returns the data most recently written to that address through the slave port, merged by its byte enables.
- R11: The line index is the low log2(LINES) bits of the word address and the tag is the remaining upper bits. An access whose index matches but whose tag differs replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_read_i | input | 1 | Requester read strobe |
| s_write_i | input | 1 | Requester write strobe |
| s_addr_i | input | ADDR_W | Requester word address |
| s_wdata_i | input | DATA_W | Requester write data |
| s_be_i | input | DATA_W/8 | Requester byte enables |
| s_burst_i | input | BURST_W | Requester read burst length |
| s_wait_o | output | 1 | Stall to requester |
| s_rdv_o | output | 1 | Read beat valid to requester |
| s_rdata_o | output | DATA_W | Read beat data to requester |
| m_read_o | output | 1 | Memory read strobe |
| m_write_o | output | 1 | Memory write strobe |
| m_addr_o | output | ADDR_W | Memory word address |
| m_wdata_o | output | DATA_W | Memory write data |
| m_be_o | output | DATA_W/8 | Memory byte enables |
| m_burst_o | output | BURST_W | Memory burst length |
| m_wait_i | input | 1 | Stall from memory |
| m_rdv_i | input | 1 | Read beat valid from memory |
| m_rdata_i | input | DATA_W | Read beat data from memory |

## Verification
The hardest case to reach is a burst that partly hits: its leading beats are already cached and a later beat is not. Only this case shows that the scan escalates the whole burst to memory instead of returning the cached beats first. The stimulus first caches a short run of words and then reads a longer burst that starts inside that run. It also runs a maximum-length miss while the memory model inserts wait cycles and gaps between beats. This exercises request holding and blocking while beats are sparse. Tag conflicts come from two addresses that share an index.

// File: rtl/mm_cache_pkg.sv
package mm_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HIT,
    ST_MREQ,
    ST_MDATA,
    ST_WREQ
  } cache_st_e;
endpackage

// File: rtl/mm_beat_ctr.sv
module mm_beat_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mm_line_store.sv
module mm_line_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   look_addr_i,
  output logic                hit_o,
  output logic [DATA_W-1:0]   look_data_o,
  input  logic                upd_i,
  input  logic                alloc_i,
  input  logic [ADDR_W-1:0]   upd_addr_i,
  input  logic [DATA_W-1:0]   upd_data_i,
  input  logic [DATA_W/8-1:0] upd_be_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int BE_W  = DATA_W / 8;

  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0]  l_idx, u_idx;
  logic [TAG_W-1:0]  l_tag, u_tag;
  logic [DATA_W-1:0] merged;

  assign l_idx = look_addr_i[IDX_W-1:0];
  assign l_tag = look_addr_i[ADDR_W-1:IDX_W];
  assign u_idx = upd_addr_i[IDX_W-1:0];
  assign u_tag = upd_addr_i[ADDR_W-1:IDX_W];

  assign hit_o       = vld_q[l_idx] && (tag_q[l_idx] == l_tag);
  assign look_data_o = dat_q[l_idx];

  for (genvar b = 0; b < BE_W; b++) begin : g_be
    assign merged[b*8 +: 8] = upd_be_i[b] ? upd_data_i[b*8 +: 8] : dat_q[u_idx][b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (upd_i && alloc_i) begin
      vld_q[u_idx] <= 1'b1;
      tag_q[u_idx] <= u_tag;
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_i) dat_q[u_idx] <= merged;
  end
endmodule

// File: rtl/mm_cache.sv
module mm_cache
  import mm_cache_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 4,
  parameter int LINES   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_read_i,
  input  logic                s_write_i,
  input  logic [ADDR_W-1:0]   s_addr_i,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic [DATA_W/8-1:0] s_be_i,
  input  logic [BURST_W-1:0]  s_burst_i,
  output logic                s_wait_o,
  output logic                s_rdv_o,
  output logic [DATA_W-1:0]   s_rdata_o,
  output logic                m_read_o,
  output logic                m_write_o,
  output logic [ADDR_W-1:0]   m_addr_o,
  output logic [DATA_W-1:0]   m_wdata_o,
  output logic [DATA_W/8-1:0] m_be_o,
  output logic [BURST_W-1:0]  m_burst_o,
  input  logic                m_wait_i,
  input  logic                m_rdv_i,
  input  logic [DATA_W-1:0]   m_rdata_i
);
  localparam int BE_W  = DATA_W / 8;
  localparam int PAD_W = ADDR_W - BURST_W;

  cache_st_e st_q, st_d;
  logic               up_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] len_q, scan_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [BE_W-1:0]    be_q;

  logic               acc_wr, acc_rd;
  logic [BURST_W-1:0] len_eff, s_cnt, m_cnt, hit_off, fill_off;
  logic               s_last, m_last, m_acc;
  logic [ADDR_W-1:0]  look_addr, upd_addr;
  logic               hit, upd, alloc;
  logic [DATA_W-1:0]  look_data, upd_data;
  logic [BE_W-1:0]    upd_be;

  assign s_wait_o = !up_q || (st_q != ST_IDLE);
  assign acc_wr   = s_write_i && !s_wait_o;
  assign acc_rd   = s_read_i && !s_write_i && !s_wait_o;
  assign len_eff  = (s_burst_i == '0) ? BURST_W'(1) : s_burst_i;
  assign m_acc    = m_read_o && !m_wait_i;

  // beat offset within the burst = length minus beats still owed
  assign hit_off  = len_q - s_cnt;
  assign fill_off = len_q - m_cnt;

  always_comb begin
    case (st_q)
      ST_SCAN: look_addr = base_q + {{PAD_W{1'b0}}, scan_q};
      ST_HIT:  look_addr = base_q + {{PAD_W{1'b0}}, hit_off};
      default: look_addr = s_addr_i;
    endcase
  end

  always_comb begin
    if (st_q == ST_MDATA) begin
      upd      = m_rdv_i;
      alloc    = 1'b1;
      upd_addr = base_q + {{PAD_W{1'b0}}, fill_off};
      upd_data = m_rdata_i;
      upd_be   = '1;
    end else begin
      upd      = acc_wr && hit;
      alloc    = 1'b0;
      upd_addr = s_addr_i;
      upd_data = s_wdata_i;
      upd_be   = s_be_i;
    end
  end

  mm_line_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .look_addr_i(look_addr),
    .hit_o      (hit),
    .look_data_o(look_data),
    .upd_i      (upd),
    .alloc_i    (alloc),
    .upd_addr_i (upd_addr),
    .upd_data_i (upd_data),
    .upd_be_i   (upd_be)
  );

  mm_beat_ctr #(.CNT_W(BURST_W)) u_s_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (acc_rd),
    .load_val_i(len_eff),
    .dec_i     (s_rdv_o),
    .cnt_o     (s_cnt),
    .last_o    (s_last)
  );

  mm_beat_ctr #(.CNT_W(BURST_W)) u_m_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (m_acc),
    .load_val_i(len_q),
    .dec_i     (m_rdv_i),
    .cnt_o     (m_cnt),
    .last_o    (m_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (acc_wr)      st_d = ST_WREQ;
        else if (acc_rd) st_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (!hit)                            st_d = ST_MREQ;
        else if (scan_q == len_q - BURST_W'(1)) st_d = ST_HIT;
      end
      ST_HIT:   if (s_last)             st_d = ST_IDLE;
      ST_MREQ:  if (!m_wait_i)          st_d = ST_MDATA;
      ST_MDATA: if (m_rdv_i && m_last)  st_d = ST_IDLE;
      ST_WREQ:  if (!m_wait_i)          st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      up_q    <= 1'b0;
      base_q  <= '0;
      len_q   <= BURST_W'(1);
      scan_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      st_q <= st_d;
      up_q <= 1'b1;
      if (acc_wr) begin
        base_q  <= s_addr_i;
        wdata_q <= s_wdata_i;
        be_q    <= s_be_i;
        len_q   <= BURST_W'(1);
      end else if (acc_rd) begin
        base_q <= s_addr_i;
        len_q  <= len_eff;
        scan_q <= '0;
        be_q   <= '1;
      end else if (st_q == ST_SCAN && hit) begin
        scan_q <= scan_q + BURST_W'(1);
      end
    end
  end

  assign s_rdv_o   = (st_q == ST_HIT) || (st_q == ST_MDATA && m_rdv_i);
  assign s_rdata_o = (st_q == ST_HIT) ? look_data : m_rdata_i;
  assign m_read_o  = (st_q == ST_MREQ);
  assign m_write_o = (st_q == ST_WREQ);
  assign m_addr_o  = base_q;
  assign m_wdata_o = wdata_q;
  assign m_be_o    = be_q;
  assign m_burst_o = len_q;
endmodule

// File: rtl/mm_cache_chk.sv
module mm_cache_chk #(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                s_read_i,
  input logic                s_write_i,
  input logic [BURST_W-1:0]  s_burst_i,
  input logic                s_wait_o,
  input logic                s_rdv_o,
  input logic                m_read_o,
  input logic                m_write_o,
  input logic [ADDR_W-1:0]   m_addr_o,
  input logic [DATA_W-1:0]   m_wdata_o,
  input logic [DATA_W/8-1:0] m_be_o,
  input logic [BURST_W-1:0]  m_burst_o,
  input logic                m_wait_i,
  input logic                m_rdv_i
);
  logic [BURST_W-1:0] f_s_cnt, f_m_cnt;
  logic               f_up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_s_cnt <= '0;
      f_m_cnt <= '0;
      f_up    <= 1'b0;
    end else begin
      f_up <= 1'b1;
      if (s_read_i && !s_write_i && !s_wait_o)
        f_s_cnt <= (s_burst_i == '0) ? BURST_W'(1) : s_burst_i;
      else if (s_rdv_o && f_s_cnt != '0)
        f_s_cnt <= f_s_cnt - BURST_W'(1);
      if (m_read_o && !m_wait_i)
        f_m_cnt <= m_burst_o;
      else if (m_rdv_i && f_m_cnt != '0)
        f_m_cnt <= f_m_cnt - BURST_W'(1);
    end
  end

  AST_QUIET_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !f_up |-> (!m_read_o && !m_write_o)); // R1
  AST_NO_DUAL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_read_o && m_write_o)); // R2
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_read_o || m_write_o) && m_wait_i) |=> ($stable(m_read_o) && $stable(m_write_o)
      && $stable(m_addr_o) && $stable(m_wdata_o) && $stable(m_be_o) && $stable(m_burst_o))); // R3
  AST_BURST_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_read_o && !m_wait_i) |-> (m_burst_o != '0)); // R4
  AST_SLAVE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_s_cnt != '0 && !(f_s_cnt == BURST_W'(1) && s_rdv_o)) |-> s_wait_o); // R5
  AST_NO_STRAY_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_s_cnt == '0) |-> !s_rdv_o); // R6
  AST_ONE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_m_cnt != '0) |-> (!m_read_o && !m_write_o)); // R8
endmodule

bind mm_cache mm_cache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BURST_W(BURST_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .s_read_i (s_read_i),
  .s_write_i(s_write_i),
  .s_burst_i(s_burst_i),
  .s_wait_o (s_wait_o),
  .s_rdv_o  (s_rdv_o),
  .m_read_o (m_read_o),
  .m_write_o(m_write_o),
  .m_addr_o (m_addr_o),
  .m_wdata_o(m_wdata_o),
  .m_be_o   (m_be_o),
  .m_burst_o(m_burst_o),
  .m_wait_i (m_wait_i),
  .m_rdv_i  (m_rdv_i)
);

// File: tb/mm_cache_test.sv
module mm_cache_test;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int BW  = 4;
  localparam int LN  = 16;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic           s_read = 1'b0, s_write = 1'b0;
  logic [AW-1:0]  s_addr = '0;
  logic [DW-1:0]  s_wdata = '0;
  logic [BEW-1:0] s_be = '0;
  logic [BW-1:0]  s_burst = '0;
  logic           s_wait, s_rdv;
  logic [DW-1:0]  s_rdata;
  logic           m_read, m_write;
  logic [AW-1:0]  m_addr;
  logic [DW-1:0]  m_wdata;
  logic [BEW-1:0] m_be;
  logic [BW-1:0]  m_burst;
  logic           m_wait = 1'b0, m_rdv = 1'b0;
  logic [DW-1:0]  m_rdata = '0;

  mm_cache #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(BW), .LINES(LN)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_read_i(s_read), .s_write_i(s_write), .s_addr_i(s_addr), .s_wdata_i(s_wdata),
    .s_be_i(s_be), .s_burst_i(s_burst), .s_wait_o(s_wait), .s_rdv_o(s_rdv), .s_rdata_o(s_rdata),
    .m_read_o(m_read), .m_write_o(m_write), .m_addr_o(m_addr), .m_wdata_o(m_wdata),
    .m_be_o(m_be), .m_burst_o(m_burst), .m_wait_i(m_wait), .m_rdv_i(m_rdv), .m_rdata_i(m_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0]  mem [1<<AW];
  int             n_mrd = 0, n_mwr = 0;
  logic [AW-1:0]  l_raddr = '0, l_waddr = '0;
  logic [BW-1:0]  l_rburst = '0, l_wburst = '0;
  logic [DW-1:0]  l_wdata = '0;
  logic [BEW-1:0] l_wbe = '0;
  bit             wait_mode = 1'b0, gap_mode = 1'b0, pend = 1'b0;
  int             cyc = 0, rem = 0;
  logic [AW-1:0]  ra = '0;
  logic [63:0]    p_snap = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] snap();
    return {12'h0, m_read, m_write, m_addr, m_wdata, m_be, m_burst};
  endfunction

  // memory model: acts at negedges, away from the design's active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_wait = 1'b0; m_rdv = 1'b0; rem = 0; pend = 1'b0;
    end else begin
      if (pend && snap() != p_snap) chk(1'b0, "R3 master request changed under wait", snap(), p_snap);
      if (m_read && m_write) chk(1'b0, "R2 master read and write together", 2'b11, 2'b00);
      m_rdv = 1'b0;
      m_rdata = 32'hDEAD_BEEF;
      if (rem > 0 && !(gap_mode && (cyc % 2 == 0))) begin
        m_rdv = 1'b1; m_rdata = mem[ra]; ra = ra + AW'(1); rem--;
      end
      m_wait = wait_mode && (cyc % 3 != 0);
      if (m_read && !m_wait) begin
        if (m_burst == '0) chk(1'b0, "R4 master read with zero burst", m_burst, 1);
        rem = int'(m_burst); ra = m_addr; n_mrd++; l_raddr = m_addr; l_rburst = m_burst;
      end
      if (m_write && !m_wait) begin
        for (int b = 0; b < BEW; b++)
          if (m_be[b]) mem[m_addr][b*8 +: 8] = m_wdata[b*8 +: 8];
        n_mwr++; l_waddr = m_addr; l_wdata = m_wdata; l_wbe = m_be; l_wburst = m_burst;
      end
      pend = (m_read || m_write) && m_wait;
      p_snap = snap();
    end
  end

  task automatic wait_accept();
    forever begin
      bit w = s_wait;
      @(posedge clk);
      if (!w) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int len, input bit exp_miss, input string req);
    int nb = (len == 0) ? 1 : len;
    int mrd0 = n_mrd;
    int got = 0;
    int out;
    logic [DW-1:0] exp_d [16];
    for (int i = 0; i < nb; i++) exp_d[i] = mem[AW'(int'(a) + i)];
    @(negedge clk); #1;
    s_read = 1'b1; s_addr = a; s_burst = BW'(len);
    wait_accept();
    out = nb;
    @(negedge clk); #1;
    s_read = 1'b0;
    for (int t = 0; t < 300 && out > 0; t++) begin
      if (!(out == 1 && s_rdv) && !s_wait) chk(1'b0, "R5 wait low with beats outstanding", s_wait, 1);
      if (s_rdv) begin
        chk(s_rdata == exp_d[got], req, s_rdata, exp_d[got]);
        got++; out--;
      end
      @(negedge clk); #1;
    end
    chk(got == nb, "R6 beat count", got, nb);
    for (int t = 0; t < 3; t++) begin
      if (s_rdv) chk(1'b0, "R6 data valid with nothing outstanding", 1, 0);
      @(negedge clk); #1;
    end
    chk(!s_wait, "R5 wait released when idle", s_wait, 0);
    if (exp_miss) begin
      chk(n_mrd == mrd0 + 1, "R8 one master burst on miss", n_mrd - mrd0, 1);
      chk(l_raddr == a, "R8 master burst start address", l_raddr, a);
      chk(int'(l_rburst) == nb, "R8 master burst length", l_rburst, nb);
    end else begin
      chk(n_mrd == mrd0, "R7 hit burst issued no master read", n_mrd - mrd0, 0);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [BEW-1:0] be,
                          input logic [BW-1:0] bl);
    int mwr0 = n_mwr;
    @(negedge clk); #1;
    s_write = 1'b1; s_addr = a; s_wdata = d; s_be = be; s_burst = bl;
    wait_accept();
    @(negedge clk); #1;
    s_write = 1'b0;
    for (int t = 0; t < 50 && n_mwr == mwr0; t++) begin @(negedge clk); #1; end
    chk(n_mwr == mwr0 + 1, "R9 one master write", n_mwr - mwr0, 1);
    chk(l_waddr == a, "R9 write address", l_waddr, a);
    chk(l_wdata == d, "R9 write data", l_wdata, d);
    chk(l_wbe == be, "R9 write byte enables", l_wbe, be);
    chk(l_wburst == BW'(1), "R9 write burst length 1", l_wburst, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk(!m_read && !m_write, "R1 master quiet in reset", {m_read, m_write}, 0);
    chk(!s_rdv, "R1 no data valid in reset", s_rdv, 0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(!m_read && !m_write, "R1 master quiet after reset", {m_read, m_write}, 0);
  endtask

  task automatic t_cold_and_hit();
    do_read(AW'('h010), 4, 1'b1, "R1 cold read misses, data R8");
    do_read(AW'('h010), 4, 1'b0, "R7 hit data");
  endtask

  task automatic t_write_hit();
    do_write(AW'('h011), 32'hA1B2_C3D4, 4'b0101, BW'(1));
    do_read(AW'('h011), 1, 1'b0, "R10 merged bytes after write hit R9");
  endtask

  task automatic t_write_miss();
    do_write(AW'('h300), 32'h1357_9BDF, 4'b1111, BW'(3));
    do_read(AW'('h300), 1, 1'b1, "R9 miss not allocated, R10 data");
  endtask

  task automatic t_partial();
    do_read(AW'('h012), 6, 1'b1, "R8 partial hit goes to memory");
    do_read(AW'('h012), 6, 1'b0, "R7 refilled burst hits");
  endtask

  task automatic t_conflict();
    do_read(AW'('h210), 1, 1'b1, "R11 same index other tag misses");
    do_read(AW'('h010), 1, 1'b1, "R11 evicted line misses");
  endtask

  task automatic t_zero_burst();
    do_read(AW'('h080), 0, 1'b1, "R4 zero burst read as one beat");
    do_read(AW'('h080), 0, 1'b0, "R4 zero burst hit");
  endtask

  task automatic t_stress();
    wait_mode = 1'b1; gap_mode = 1'b1;
    do_read(AW'('h040), 15, 1'b1, "R8 long miss under stalls");
    do_write(AW'('h045), 32'h0F0F_F0F0, 4'b1111, BW'(1));
    do_read(AW'('h040), 15, 1'b0, "R10 long hit after write");
    do_write(AW'('h3F0), 32'h2468_ACE0, 4'b0010, BW'(1));
    do_read(AW'('h3F0), 1, 1'b1, "R3 miss after stalled write");
    wait_mode = 1'b0; gap_mode = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hC0DE_0000 ^ (i * 32'h0001_0203);
    t_reset();
    t_cold_and_hit();
    t_write_hit();
    t_write_miss();
    t_partial();
    t_conflict();
    t_zero_burst();
    t_stress();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      chk(1'b0, "R6 watchdog expired", 0, 1);
      report();
      $finish;
    end
  end
endmodule